// File: doc/BRIEF.md
# DSP Serial Port Control Register

This block is the 16-bit control and status word of a serial DSP port inside an audio controller. A host reaches it over a plain register bus: an address, write data, a write strobe, a read strobe and a combinational read-data return. The stored fields choose which of six sample-rate strobes drives the port's frame sync. They also enable interception of five audio streams, enable takeover of the two serial-audio inputs, and switch the DSP modem path on.

Some bits are commands rather than state. Writing 1 to the FIFO-resync bit or the modem-resync bit produces a one-cycle pulse on the matching output. Writing 1 to the DSP-interrupt bit raises a sticky host interrupt, but only while the external interrupt-enable input is high. An acknowledge input clears that interrupt. Command bits always read back as 0.

Two read-only status bits follow the direction of the most recent host access to each of two mailbox addresses. A write to a mailbox sets its bit and a read clears it. The mailbox data path lives outside this block. Reads of a mailbox address return zero from this block.

Top module: `dsp_port_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, every output is 0 and the control word reads 0x0000.
- R2: The frame-sync select field is bits [2:0]. For codes 0 to 5, `fsync_o` equals `rate_stb_i[code]` from the previous clock. Bit 0 is the maximum rate, 1 is serial input 0, 2 is serial input 1, 3 is the synthesizer, 4 is playback and 5 is capture.
- R3: Select codes 6 and 7 hold `fsync_o` low whatever the rate strobes do.
- R4: The intercept enables are bits [7:3]: bit 3 serial input 0, bit 4 serial input 1, bit 5 synthesizer, bit 6 playback, bit 7 capture. They drive `intercept_en_o[4:0]` in that order from the clock after a control write.
- R5: The takeover enables are bits [9:8] (bit 8 serial input 0, bit 9 serial input 1) and drive `takeover_en_o[1:0]`.
- R6: Modem enable is bit 12, is stored, drives `modem_en_o` and reads back.
- R7: Writing 1 to bit 10 of the control word pulses `fifo_resync_o` high for exactly the following cycle. The bit reads back as 0.
- R8: Writing 1 to bit 11 of the control word pulses `modem_resync_o` high for exactly the following cycle. The bit reads back as 0.
- R9: A control write with bit 13 set while `irq_en_i` is high sets `host_irq_o` from the next cycle. The output holds until acknowledged. With `irq_en_i` low the write has no effect, and bit 13 reads back as 0.
- R10: `irq_ack_i` clears `host_irq_o` on the next cycle. If a set and an acknowledge arrive together, the set wins.
- R11: Bit 14 (mailbox 0) and bit 15 (mailbox 1) read 1 after a write to that mailbox's address and 0 after a read of it. Control writes do not alter them.
- R12: `rdata_o` is 0 unless `rd_i` is high with the control address. Reads of other addresses return 0 and change no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host register address |
| wdata_i | input | 16 | Host write data |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| rdata_o | output | 16 | Host read data (combinational) |
| rate_stb_i | input | 6 | Rate strobes indexed by select code |
| irq_en_i | input | 1 | External interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| fsync_o | output | 1 | Selected frame-sync strobe, registered |
| intercept_en_o | output | 5 | Stream intercept enables |
| takeover_en_o | output | 2 | Serial-input takeover enables |
| modem_en_o | output | 1 | DSP modem enable |
| fifo_resync_o | output | 1 | One-cycle FIFO resync pulse |
| modem_resync_o | output | 1 | One-cycle modem resync pulse |
| host_irq_o | output | 1 | Sticky host interrupt |

## Verification
The bench builds the block with a 3-bit address, the control word at 0, mailbox 0 at 5 and mailbox 1 at 7. This places one mailbox at the top of the address space and leaves unused addresses between the decoded ones. Reads and writes to the unused addresses can then be shown to leave every field untouched, and the top-address compare is exercised. All eight select codes are swept under random rate strobes. Set and acknowledge are driven in the same cycle, and the bench also writes the interrupt bit with the enable low.

// File: rtl/dspc_pkg.sv
package dspc_pkg;
    localparam int REG_W        = 16;
    localparam int FS_W         = 3;
    localparam int N_ICPT       = 5;
    localparam int N_TKO        = 2;
    localparam int N_RATE       = 6;
    localparam int N_MBOX       = 2;

    localparam int FS_LSB       = 0;
    localparam int ICPT_LSB     = 3;
    localparam int TKO_LSB      = 8;
    localparam int FIFO_RS_BIT  = 10;
    localparam int MODEM_RS_BIT = 11;
    localparam int MODEM_EN_BIT = 12;
    localparam int IRQ_BIT      = 13;
    localparam int MB0_BIT      = 14;
    localparam int MB1_BIT      = 15;

    typedef struct packed {
        logic              men;
        logic [N_TKO-1:0]  tko;
        logic [N_ICPT-1:0] icpt;
        logic [FS_W-1:0]   fs_sel;
    } cfg_t;
endpackage

// File: rtl/dspc_regs.sv
module dspc_regs
    import dspc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int MB0_ADDR  = 1,
    parameter int MB1_ADDR  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output cfg_t              cfg_o,
    output logic              fifo_rs_o,
    output logic              modem_rs_o,
    output logic              irq_req_o,
    output logic [REG_W-1:0]  rdata_o
);
    typedef struct packed {
        cfg_t              cfg;
        logic              fifo_rs;
        logic              modem_rs;
        logic [N_MBOX-1:0] mbox;
    } regs_t;

    regs_t             d, q;
    logic              ctrl_hit;
    logic              ctrl_wr;
    logic [N_MBOX-1:0] mb_hit;
    logic [REG_W-1:0]  view;
    logic              unused_wbits;

    assign ctrl_hit = (addr_i == ADDR_W'(CTRL_ADDR));
    assign ctrl_wr  = wr_i && ctrl_hit;
    assign unused_wbits = ^{wdata_i[MB1_BIT], wdata_i[MB0_BIT]};

    for (genvar i = 0; i < N_MBOX; i++) begin : g_mb
        assign mb_hit[i] = (addr_i == ADDR_W'((i == 0) ? MB0_ADDR : MB1_ADDR));
    end

    always_comb begin
        d          = q;
        d.fifo_rs  = 1'b0;
        d.modem_rs = 1'b0;
        if (ctrl_wr) begin
            d.cfg.fs_sel = wdata_i[FS_LSB +: FS_W];
            d.cfg.icpt   = wdata_i[ICPT_LSB +: N_ICPT];
            d.cfg.tko    = wdata_i[TKO_LSB +: N_TKO];
            d.cfg.men    = wdata_i[MODEM_EN_BIT];
            d.fifo_rs    = wdata_i[FIFO_RS_BIT];
            d.modem_rs   = wdata_i[MODEM_RS_BIT];
        end
        for (int i = 0; i < N_MBOX; i++) begin
            if (wr_i && mb_hit[i])      d.mbox[i] = 1'b1;
            else if (rd_i && mb_hit[i]) d.mbox[i] = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        view                        = '0;
        view[FS_LSB +: FS_W]        = q.cfg.fs_sel;
        view[ICPT_LSB +: N_ICPT]    = q.cfg.icpt;
        view[TKO_LSB +: N_TKO]      = q.cfg.tko;
        view[MODEM_EN_BIT]          = q.cfg.men;
        view[MB0_BIT]               = q.mbox[0];
        view[MB1_BIT]               = q.mbox[1];
    end

    assign rdata_o    = (rd_i && ctrl_hit) ? view : '0;
    assign cfg_o      = q.cfg;
    assign fifo_rs_o  = q.fifo_rs;
    assign modem_rs_o = q.modem_rs;
    assign irq_req_o  = ctrl_wr && wdata_i[IRQ_BIT];

    // R7
    fifo_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && wdata_i[FIFO_RS_BIT]) |=> fifo_rs_o);
    // R7
    fifo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ctrl_wr && wdata_i[FIFO_RS_BIT]) |=> !fifo_rs_o);
    // R8
    modem_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && wdata_i[MODEM_RS_BIT]) |=> modem_rs_o);
    // R8
    modem_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ctrl_wr && wdata_i[MODEM_RS_BIT]) |=> !modem_rs_o);
    // R4
    icpt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr |=> (cfg_o.icpt == $past(wdata_i[ICPT_LSB +: N_ICPT])));
    // R12
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> $stable(cfg_o));
    // R11
    mb0_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && mb_hit[0]) |=> q.mbox[0]);
    // R11
    mb1_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !wr_i && mb_hit[1]) |=> !q.mbox[1]);
    // R12
    rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |-> (rdata_o == '0));
endmodule

// File: rtl/dspc_fsync.sv
module dspc_fsync
    import dspc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FS_W-1:0]   sel_i,
    input  logic [N_RATE-1:0] rate_stb_i,
    output logic              fsync_o
);
    localparam int SPAN = 1 << FS_W;

    logic [SPAN-1:0] padded;
    logic            fsync_d, fsync_q;

    assign padded = SPAN'(rate_stb_i);

    always_comb begin
        fsync_d = padded[sel_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fsync_q <= 1'b0;
        else         fsync_q <= fsync_d;
    end

    assign fsync_o = fsync_q;

    // R3
    fsync_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sel_i) >= N_RATE) |=> !fsync_o);
    // R2
    fsync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_stb_i == '0) |=> !fsync_o);
endmodule

// File: rtl/dspc_irq.sv
module dspc_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_req_i,
    input  logic irq_en_i,
    input  logic ack_i,
    output logic irq_o
);
    logic irq_d, irq_q;
    logic set_ok;

    assign set_ok = set_req_i && irq_en_i;

    always_comb begin
        irq_d = irq_q;
        if (set_ok)     irq_d = 1'b1;
        else if (ack_i) irq_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R9
    irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_ok |=> irq_o);
    // R9
    irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !ack_i) |=> irq_o);
    // R9
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && !set_ok) |=> !irq_o);
    // R10
    irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !set_ok) |=> !irq_o);
endmodule

// File: rtl/dsp_port_ctrl.sv
module dsp_port_ctrl
    import dspc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int MB0_ADDR  = 1,
    parameter int MB1_ADDR  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [15:0]       rdata_o,
    input  logic [5:0]        rate_stb_i,
    input  logic              irq_en_i,
    input  logic              irq_ack_i,
    output logic              fsync_o,
    output logic [4:0]        intercept_en_o,
    output logic [1:0]        takeover_en_o,
    output logic              modem_en_o,
    output logic              fifo_resync_o,
    output logic              modem_resync_o,
    output logic              host_irq_o
);
    cfg_t cfg;
    logic irq_req;

    dspc_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .MB0_ADDR (MB0_ADDR),
        .MB1_ADDR (MB1_ADDR)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .wr_i      (wr_i),
        .rd_i      (rd_i),
        .cfg_o     (cfg),
        .fifo_rs_o (fifo_resync_o),
        .modem_rs_o(modem_resync_o),
        .irq_req_o (irq_req),
        .rdata_o   (rdata_o)
    );

    dspc_fsync u_fsync (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (cfg.fs_sel),
        .rate_stb_i(rate_stb_i),
        .fsync_o   (fsync_o)
    );

    dspc_irq u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_req_i(irq_req),
        .irq_en_i (irq_en_i),
        .ack_i    (irq_ack_i),
        .irq_o    (host_irq_o)
    );

    assign intercept_en_o = cfg.icpt;
    assign takeover_en_o  = cfg.tko;
    assign modem_en_o     = cfg.men;
endmodule

// File: tb/tb_dsp_port_ctrl.sv
`timescale 1ns/1ps
module tb_dsp_port_ctrl;
    localparam int AW = 3;
    localparam int CA = 0;
    localparam int M0 = 5;
    localparam int M1 = 7;

    logic          clk = 0;
    logic          rst_ni = 0;
    logic [AW-1:0] addr = 0;
    logic [15:0]   wdata = 0;
    logic          wr = 0, rd = 0;
    logic [15:0]   rdata;
    logic [5:0]    rate_stb = 0;
    logic          irq_en = 0, irq_ack = 0;
    logic          fsync, modem_en, fifo_rs, modem_rs, host_irq;
    logic [4:0]    icpt;
    logic [1:0]    tko;

    int checks = 0, errors = 0;
    bit done = 0, run_rand = 0;

    always #2.5 clk = ~clk;

    dsp_port_ctrl #(.ADDR_W(AW), .CTRL_ADDR(CA), .MB0_ADDR(M0), .MB1_ADDR(M1)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
        .rdata_o(rdata), .rate_stb_i(rate_stb), .irq_en_i(irq_en), .irq_ack_i(irq_ack),
        .fsync_o(fsync), .intercept_en_o(icpt), .takeover_en_o(tko), .modem_en_o(modem_en),
        .fifo_resync_o(fifo_rs), .modem_resync_o(modem_rs), .host_irq_o(host_irq));

    // behavioural reference state
    int m_sel, m_icpt, m_tko, m_men, m_fifo, m_mrs, m_irq, m_mb0, m_mb1, m_fs, m_fs_rsv;

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_sel <= 0; m_icpt <= 0; m_tko <= 0; m_men <= 0; m_fifo <= 0; m_mrs <= 0;
            m_irq <= 0; m_mb0 <= 0; m_mb1 <= 0; m_fs <= 0; m_fs_rsv <= 0;
        end else begin
            m_fs     <= (m_sel < 6) ? int'(rate_stb[m_sel]) : 0;
            m_fs_rsv <= (m_sel >= 6) ? 1 : 0;
            m_fifo   <= (wr && addr == CA && wdata[10]) ? 1 : 0;
            m_mrs    <= (wr && addr == CA && wdata[11]) ? 1 : 0;
            if (wr && addr == CA) begin
                m_sel  <= wdata % 8;
                m_icpt <= (wdata / 8) % 32;
                m_tko  <= (wdata / 256) % 4;
                m_men  <= (wdata / 4096) % 2;
            end
            if (wr && addr == CA && wdata[13] && irq_en) m_irq <= 1;
            else if (irq_ack) m_irq <= 0;
            if (addr == M0 && wr) m_mb0 <= 1; else if (addr == M0 && rd) m_mb0 <= 0;
            if (addr == M1 && wr) m_mb1 <= 1; else if (addr == M1 && rd) m_mb1 <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int view, erd;
            view = m_sel + m_icpt * 8 + m_tko * 256 + m_men * 4096 + m_mb0 * 16384 + m_mb1 * 32768;
            erd  = (rd && addr == CA) ? view : 0;
            if (!rst_ni) begin
                chk({fsync, icpt, tko, modem_en, fifo_rs, modem_rs, host_irq} == '0, "R1 outputs",
                    int'({fsync, icpt, tko, modem_en, fifo_rs, modem_rs, host_irq}), 0);
                chk(rdata == 16'(erd), "R1 rdata", int'(rdata), erd);
            end else begin
                chk(int'(fsync) == m_fs, m_fs_rsv ? "R3 fsync" : "R2 fsync", int'(fsync), m_fs);
                chk(int'(icpt) == m_icpt, "R4 intercept", int'(icpt), m_icpt);
                chk(int'(tko) == m_tko, "R5 takeover", int'(tko), m_tko);
                chk(int'(modem_en) == m_men, "R6 modem_en", int'(modem_en), m_men);
                chk(int'(fifo_rs) == m_fifo, "R7 fifo_resync", int'(fifo_rs), m_fifo);
                chk(int'(modem_rs) == m_mrs, "R8 modem_resync", int'(modem_rs), m_mrs);
                chk(int'(host_irq) == m_irq, "R9 R10 host_irq", int'(host_irq), m_irq);
                chk(int'(rdata) == erd, "R11 R12 rdata", int'(rdata), erd);
            end
        end
    end

    always @(posedge clk) #1 rate_stb <= 6'($urandom);

    task automatic bus(input bit w, input bit r, input int a, input int d);
        @(posedge clk); #1;
        wr = w; rd = r; addr = AW'(a); wdata = 16'(d);
        @(posedge clk); #1;
        wr = 0; rd = 0; addr = AW'(CA);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        // R1: outputs and readback during reset
        idle(2);
        #1 rd = 1; addr = AW'(CA);
        idle(2);
        #1 rd = 0;
        rst_ni = 1;
        bus(0, 1, CA, 0);
        // R2 R3: sweep every select code under random strobes
        for (int c = 0; c < 8; c++) begin
            bus(1, 0, CA, c);
            idle(24);
            bus(0, 1, CA, 0);
        end
        // R4 R5 R6: field patterns, read back
        bus(1, 0, CA, 16'h0015 << 3 | 16'h0100 | 16'h1000 | 2);
        bus(0, 1, CA, 0);
        bus(1, 0, CA, 16'h000A << 3 | 16'h0200 | 1);
        bus(0, 1, CA, 0);
        bus(1, 0, CA, 16'h1FF8);
        bus(0, 1, CA, 0);
        // R7 R8: command pulses, one and back to back
        bus(1, 0, CA, 16'h0400);
        bus(1, 0, CA, 16'h0800);
        @(posedge clk); #1 wr = 1; addr = AW'(CA); wdata = 16'h0C00;
        @(posedge clk); #1 wdata = 16'h0C00;
        @(posedge clk); #1 wr = 0;
        bus(0, 1, CA, 0);
        // R9: interrupt gated off, then on
        irq_en = 0;
        bus(1, 0, CA, 16'h2000);
        idle(3);
        irq_en = 1;
        bus(1, 0, CA, 16'h2000);
        idle(5);
        bus(0, 1, CA, 0);
        // R10: acknowledge clears, set wins over ack
        @(posedge clk); #1 irq_ack = 1;
        @(posedge clk); #1 irq_ack = 0;
        @(posedge clk); #1 irq_ack = 1; wr = 1; addr = AW'(CA); wdata = 16'h2000;
        @(posedge clk); #1 irq_ack = 0; wr = 0;
        idle(3);
        @(posedge clk); #1 irq_ack = 1;
        @(posedge clk); #1 irq_ack = 0;
        // R11: mailbox directions, control writes leave them alone
        bus(1, 0, M0, 16'hFFFF);
        bus(0, 1, CA, 0);
        bus(1, 0, M1, 0);
        bus(1, 0, CA, 16'h0000);
        bus(0, 1, CA, 0);
        bus(0, 1, M0, 0);
        bus(0, 1, CA, 0);
        bus(1, 0, CA, 16'hC000);
        bus(0, 1, M1, 0);
        bus(0, 1, CA, 0);
        // R12: unused addresses and reads of mailboxes return 0
        bus(1, 0, CA, 16'h1ABC);
        for (int a = 1; a < 8; a++) begin
            bus(1, 0, a, 16'hFFFF);
            bus(0, 1, a, 0);
        end
        bus(0, 1, CA, 0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            wr = ($urandom % 3) == 0;
            rd = !wr && ($urandom % 2);
            addr = AW'($urandom);
            wdata = 16'($urandom);
            irq_en = $urandom % 2;
            irq_ack = ($urandom % 5) == 0;
        end
        @(posedge clk); #1 wr = 0; rd = 0; irq_ack = 0;
        idle(4);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule